// File: doc/BRIEF.md
# Byte Transmit Queue with Write Handshake

This block is a ring-buffer queue of bytes that sits between a producer and a consumer inside a transmit path. The producer writes through a level-based request/acknowledge handshake: it raises a store request with a byte and holds it. The queue takes the byte exactly once and keeps the acknowledge high until the producer drops the request. The consumer reads with a plain get strobe. Every enabled cycle in which get is high and the queue holds data removes one byte. That byte appears on a registered output in the following cycle.

Two pointers track the ring. After reset the read pointer sits at slot 0 and the write pointer at slot 1. The queue is empty when the slot after the read pointer is the write pointer. It is full when the slot after the write pointer is the read pointer. A queue of DEPTH slots therefore holds DEPTH-2 bytes. The flags and the occupancy count are combinational functions of the pointers as they stand at the start of the cycle. A global enable freezes all state changes, and a debug output copies it.

Top module: `byte_txq_ring`

## Requirements
- R1: A synchronous active-high reset sets the read pointer to slot 0 and the write pointer to slot 1, clears the data output to 0 and clears the handshake; afterwards empty=1, full=0, level=0 and ack=0 while store is low.
- R2: empty is 1 exactly when the queue holds no byte and full is 1 exactly when it holds DEPTH-2 bytes; both are evaluated from the pointers before the cycle's updates.
- R3: level equals the number of stored bytes: write minus read minus one when read is below write, otherwise DEPTH minus read plus write minus one.
- R4: A push happens when enable, store, not-full and a clear handshake coincide; it stores byte_i, sets the handshake, and ack is 1 in that cycle and in every later cycle while store stays high; a held request writes only one byte, and ack falls in the cycle store falls.
- R5: A store request while full writes nothing, leaves level unchanged and gives ack=0.
- R6: With enable and get high and the queue non-empty, the oldest byte is removed and appears on byte_o one clock later; this repeats every such cycle with no handshake, in first-in first-out order.
- R7: get while empty removes nothing and leaves byte_o unchanged.
- R8: With enable low, no pointer, stored byte or data output changes, while empty, full, level and ack still reflect the current state.
- R9: A push and a pop in the same cycle both take effect, leaving level unchanged.
- R10: en_dbg_o always equals en_i.
- R11: A reset in the middle of traffic discards the stored bytes and returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Global enable for all state changes |
| get_i | input | 1 | Pop strobe from the consumer |
| store_i | input | 1 | Level store request from the producer |
| byte_i | input | DATA_W | Byte to store |
| byte_o | output | DATA_W | Registered byte from the last pop |
| empty_o | output | 1 | Queue holds no byte |
| full_o | output | 1 | Queue holds DEPTH-2 bytes |
| ack_o | output | 1 | Byte-received acknowledge |
| level_o | output | $clog2(DEPTH)+1 | Number of stored bytes |
| en_dbg_o | output | 1 | Copy of en_i |

## Verification
The bench builds two copies side by side. One has DEPTH=8, a power of two, so the pointers wrap by natural overflow. The other has DEPTH=6, which selects the compare-and-clear wrap. Both receive the same inputs, and capacities of 6 and 4 bytes mean that full, wrap-around and the full-while-held-request corner are reached within a few cycles. A pseudo-random sweep over enable, get, store and data runs thousands of cycles, walking each ring around many times. An arithmetic queue model in the bench checks every output of both copies on every cycle.

// File: rtl/txq_pkg.sv
package txq_pkg;
   typedef enum logic {
      HS_IDLE = 1'b0,
      HS_HELD = 1'b1
   } hs_state_e;
endpackage

// File: rtl/txq_ptr.sv
module txq_ptr #(
   parameter int DEPTH = 1024,
   parameter int INIT  = 0,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          adv_i,
   output logic [AW-1:0] ptr_o,
   output logic [AW-1:0] nxt_o
);
   localparam bit IS_POW2 = (DEPTH == (1 << AW));

   logic [AW-1:0] ptr_q;

   generate
      if (IS_POW2) begin : g_wrap_free
         assign nxt_o = ptr_q + AW'(1);
      end else begin : g_wrap_cmp
         assign nxt_o = (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i)      ptr_q <= AW'(INIT);
      else if (adv_i) ptr_q <= nxt_o;
   end

   assign ptr_o = ptr_q;

   p_ptr_bound_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      int'(ptr_q) < DEPTH);
endmodule

// File: rtl/txq_store.sv
module txq_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 1024,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              we_i,
   input  logic [AW-1:0]     waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              re_i,
   input  logic [AW-1:0]     raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk_i) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)     rdata_q <= '0;
      else if (re_i) rdata_q <= mem[raddr_i];
   end

   assign rdata_o = rdata_q;

   p_same_slot_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (we_i && re_i) |-> (waddr_i != raddr_i));
endmodule

// File: rtl/txq_wr_hs.sv
module txq_wr_hs
   import txq_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   input  logic store_i,
   input  logic full_i,
   output logic push_o,
   output logic ack_o
);
   hs_state_e st_q;
   logic      allow;

   assign allow  = en_i && store_i && !full_i && (st_q == HS_IDLE);
   assign push_o = allow;
   assign ack_o  = store_i && ((st_q == HS_HELD) || allow);

   always_ff @(posedge clk_i) begin
      if (rst_i)         st_q <= HS_IDLE;
      else if (!store_i) st_q <= HS_IDLE;
      else if (allow)    st_q <= HS_HELD;
   end

   p_no_double_push_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      push_o |=> (!store_i || !push_o));
endmodule

// File: rtl/byte_txq_ring.sv
module byte_txq_ring #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 1024,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH) + 1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic              get_i,
   input  logic              store_i,
   input  logic [DATA_W-1:0] byte_i,
   output logic [DATA_W-1:0] byte_o,
   output logic              empty_o,
   output logic              full_o,
   output logic              ack_o,
   output logic [CW-1:0]     level_o,
   output logic              en_dbg_o
);
   generate
      if (DEPTH < 4) begin : g_bad_depth
         $error("byte_txq_ring: DEPTH must be at least 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("byte_txq_ring: DATA_W must be at least 1");
      end
   endgenerate

   logic [AW-1:0] rd_q, rd_nxt, wr_q, wr_nxt;
   logic          pop, push;

   assign empty_o = (rd_nxt == wr_q);
   assign full_o  = (wr_nxt == rd_q);
   assign pop     = en_i && get_i && !empty_o;

   always_comb begin
      if (rd_q < wr_q)
         level_o = CW'(wr_q) - CW'(rd_q) - CW'(1);
      else
         level_o = CW'(DEPTH) - CW'(rd_q) + CW'(wr_q) - CW'(1);
   end

   assign en_dbg_o = en_i;

   txq_ptr #(.DEPTH(DEPTH), .INIT(0)) u_rd_ptr (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .adv_i (pop),
      .ptr_o (rd_q),
      .nxt_o (rd_nxt)
   );

   txq_ptr #(.DEPTH(DEPTH), .INIT(1)) u_wr_ptr (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .adv_i (push),
      .ptr_o (wr_q),
      .nxt_o (wr_nxt)
   );

   txq_wr_hs u_hs (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .en_i    (en_i),
      .store_i (store_i),
      .full_i  (full_o),
      .push_o  (push),
      .ack_o   (ack_o)
   );

   txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .we_i    (push),
      .waddr_i (wr_q),
      .wdata_i (byte_i),
      .re_i    (pop),
      .raddr_i (rd_nxt),
      .rdata_o (byte_o)
   );

   p_flag_excl_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      !(empty_o && full_o));

   p_level_empty_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      empty_o |-> (level_o == '0));

   p_level_full_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      full_o |-> (int'(level_o) == DEPTH - 2));

   p_held_once_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(!rst_i) && $past(ack_o) && $past(store_i) && store_i)
         |=> (level_o <= $past(level_o)));

   p_empty_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      empty_o |=> $stable(byte_o));

   p_idle_freeze_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> ($stable(level_o) && $stable(byte_o)));

   p_level_step_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> (({1'b0, level_o} <= {1'b0, $past(level_o)} + 1'b1) &&
                ({1'b0, level_o} + 1'b1 >= {1'b0, $past(level_o)})));
endmodule

// File: tb/byte_txq_ring_tb_top.sv
`timescale 1ns/1ps
module byte_txq_ring_tb_top;
   localparam int CW = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en = 1'b0, get = 1'b0, st = 1'b0;
   logic [7:0] din = '0;

   logic [7:0]    dout_w  [2];
   logic          empty_w [2];
   logic          full_w  [2];
   logic          ack_w   [2];
   logic [CW-1:0] level_w [2];
   logic          dbg_w   [2];

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   byte_txq_ring #(.DATA_W(8), .DEPTH(8)) dut_i (
      .clk_i(clk), .rst_i(rst), .en_i(en), .get_i(get), .store_i(st),
      .byte_i(din), .byte_o(dout_w[0]), .empty_o(empty_w[0]), .full_o(full_w[0]),
      .ack_o(ack_w[0]), .level_o(level_w[0]), .en_dbg_o(dbg_w[0]));

   byte_txq_ring #(.DATA_W(8), .DEPTH(6)) dut6_i (
      .clk_i(clk), .rst_i(rst), .en_i(en), .get_i(get), .store_i(st),
      .byte_i(din), .byte_o(dout_w[1]), .empty_o(empty_w[1]), .full_o(full_w[1]),
      .ack_o(ack_w[1]), .level_o(level_w[1]), .en_dbg_o(dbg_w[1]));

   // bench queue model, one per copy; capacity is DEPTH-2
   int         cap [2] = '{6, 4};
   logic [7:0] mq  [2][8];
   int         mh  [2];
   int         mo  [2];
   bit         mhs [2];
   logic [7:0] md  [2];

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int k = 0; k < 2; k++) begin
         mh[k] = 0; mo[k] = 0; mhs[k] = 0; md[k] = '0;
      end
   endtask

   // called at a negative edge: drive, check combinational outputs, clock, check byte_o
   task automatic cyc(input logic e, input logic g, input logic s, input logic [7:0] d);
      bit push [2];
      bit pop  [2];
      en = e; get = g; st = s; din = d;
      #1;
      for (int k = 0; k < 2; k++) begin
         chk("R2 empty", int'(empty_w[k]), int'(mo[k] == 0));
         chk("R2 full",  int'(full_w[k]),  int'(mo[k] == cap[k]));
         chk("R3 level", int'(level_w[k]), mo[k]);
         chk("R4 ack",   int'(ack_w[k]),   int'(s && (mhs[k] || (e && mo[k] < cap[k]))));
         chk("R10 dbg",  int'(dbg_w[k]),   int'(e));
         push[k] = e && s && !mhs[k] && (mo[k] < cap[k]);
         pop[k]  = e && g && (mo[k] > 0);
      end
      @(posedge clk);
      for (int k = 0; k < 2; k++) begin
         if (pop[k]) begin
            md[k] = mq[k][mh[k]];
            mh[k] = (mh[k] + 1) % 8;
            mo[k]--;
         end
         if (push[k]) begin
            mq[k][(mh[k] + mo[k]) % 8] = d;
            mo[k]++;
         end
         mhs[k] = s ? (mhs[k] || push[k]) : 1'b0;
      end
      @(negedge clk);
      for (int k = 0; k < 2; k++) chk("R6 byte_o", int'(dout_w[k]), int'(md[k]));
   endtask

   task automatic do_reset();
      rst = 1'b1; en = 0; get = 0; st = 0; din = '0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      model_reset();
      #1;
      for (int k = 0; k < 2; k++) begin
         chk("R1 empty", int'(empty_w[k]), 1);
         chk("R1 full",  int'(full_w[k]),  0);
         chk("R1 level", int'(level_w[k]), 0);
         chk("R1 byte_o", int'(dout_w[k]), 0);
         chk("R1 ack",   int'(ack_w[k]),   0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      logic [7:0]  sv [2];
      @(negedge clk);
      do_reset();

      // R4: held request stores one byte, ack stays high until release
      cyc(1, 0, 1, 8'hA5);
      cyc(1, 0, 1, 8'h11);
      cyc(1, 0, 1, 8'h22);
      #1;
      for (int k = 0; k < 2; k++) begin
         chk("R4 one byte per hold", int'(level_w[k]), 1);
         chk("R4 ack held", int'(ack_w[k]), 1);
      end
      cyc(1, 0, 0, 8'h00);

      // R5: fill with pulsed requests past capacity
      for (int i = 0; i < 8; i++) begin
         cyc(1, 0, 1, 8'(8'h30 + i));
         cyc(1, 0, 0, 8'h00);
      end
      st = 1'b1; #1;
      for (int k = 0; k < 2; k++) begin
         chk("R5 level at full", int'(level_w[k]), cap[k]);
         chk("R5 no ack when full", int'(ack_w[k]), 0);
      end
      cyc(1, 0, 1, 8'hEE);
      cyc(1, 0, 0, 8'h00);
      for (int k = 0; k < 2; k++) chk("R5 nothing written", int'(level_w[k]), cap[k]);

      // R8: enable low freezes pointers and data
      for (int k = 0; k < 2; k++) sv[k] = dout_w[k];
      cyc(0, 1, 1, 8'h77);
      cyc(0, 1, 0, 8'h77);
      for (int k = 0; k < 2; k++) begin
         chk("R8 level frozen", int'(level_w[k]), cap[k]);
         chk("R8 byte_o frozen", int'(dout_w[k]), int'(sv[k]));
      end

      // R6: get held high drains one byte per cycle in order
      for (int i = 0; i < 7; i++) cyc(1, 1, 0, 8'h00);
      for (int k = 0; k < 2; k++) chk("R6 drained", int'(level_w[k]), 0);

      // R7: get while empty leaves byte_o unchanged
      for (int k = 0; k < 2; k++) sv[k] = dout_w[k];
      cyc(1, 1, 0, 8'h00);
      for (int k = 0; k < 2; k++) chk("R7 byte_o held", int'(dout_w[k]), int'(sv[k]));

      // R9: push and pop in one cycle
      cyc(1, 0, 1, 8'h5A);
      cyc(1, 0, 0, 8'h00);
      cyc(1, 1, 1, 8'hC3);
      for (int k = 0; k < 2; k++) begin
         chk("R9 level kept", int'(level_w[k]), 1);
         chk("R9 popped byte", int'(dout_w[k]), 8'h5A);
      end
      cyc(1, 0, 0, 8'h00);

      // R11: reset mid-traffic
      cyc(1, 0, 1, 8'h99);
      do_reset();
      for (int k = 0; k < 2; k++) chk("R11 empty after reset", int'(empty_w[k]), 1);

      // near-exhaustive sweep over enable, get, store and data
      lf = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         cyc(lf[2:0] != 3'b000, lf[4] ^ lf[9], lf[6] | (lf[11] & lf[3]), lf[15:8]);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule